// File: doc/BRIEF.md
# Serial Gain-Control Register Bank

This block holds the gain settings of an eight-channel amplifier array. Software or a controller outside the chip sends 8-bit control words over three wires: a serial clock, a serial data line and an active-low latch strobe. Each word carries a three-bit channel selector, an enable bit and a four-bit gain code. All three wires are sampled by a faster system clock. The block finds the serial clock rising edges and the strobe falling edges itself.

When a complete word has been shifted in and the strobe falls, the block checks the word. If it is valid, the gain code is written into the register of the selected channel. For every channel the block then presents the stored code, a powersave flag and a signed step index that later gain logic turns into an actual setting. Each accepted write also raises a one-cycle notification together with the index of the channel that changed.

Top module: `serial_gain_bank`

## Requirements
- R1: After a synchronous reset every channel holds gain code 0000, every powersave flag is 1, every step index is 0 and the update pulse is low.
- R2: Serial data is taken on each rising edge of the serial clock, most significant bit first. In the resulting 8-bit word, bit 7 is the enable bit, bits 6..4 are the channel (000 = first channel at index 0, 111 = last at index 7) and bits 3..0 are the gain code.
- R3: A word whose bit 7 is 0 changes no channel and produces no update pulse.
- R4: A shifted word has no effect until the strobe falls (1 to 0). Channel registers change only together with an update pulse.
- R5: A strobe falling edge that follows any number of serial clock rises other than exactly 8 is ignored. The bit count restarts at zero, so the next correctly framed word is accepted.
- R6: The powersave flag of a channel is 1 exactly when its stored code is 0000.
- R7: The step index is a 4-bit two's-complement value equal to code minus 8 for codes 0001..1111, so it ranges from -7 to +7 and code 1000 gives 0. It is 0 in powersave and is never -8.
- R8: Each accepted write raises the update output for exactly one system clock cycle, with the written channel index on the 3-bit channel output. Rejected words raise no pulse.
- R9: A write changes only the addressed channel. All other channels keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data, MSB first |
| latch_n_i | input | 1 | Active-low latch strobe; a word commits on its falling edge |
| gain_code_o | output | 32 | Stored 4-bit code per channel, channel i at bits [4i+3:4i] |
| pwr_save_o | output | 8 | Powersave flag per channel |
| step_o | output | 32 | Signed 4-bit step index per channel, channel i at bits [4i+3:4i] |
| upd_o | output | 1 | One-cycle pulse on each accepted write |
| upd_ch_o | output | 3 | Index of the channel written with the current pulse |

## Verification
Randomly drawn words probe the decode. A random channel selector checks that the write lands in the right register and that the other seven stay put. Random codes cover the whole step mapping and the powersave case, and random enable bits separate accepted words from discarded ones. Frames of 7 and 9 bits, mixed with the proper 8-bit frames, show whether the block counts bits or only looks at the shift register contents. A directed case shifts a full word and checks before the strobe that nothing has moved yet, which shows that the strobe edge, and not the eighth clock, commits the word. Directed writes at codes 0000, 0001, 1000 and 1111 pin down the ends and the midpoint of the step scale.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
    localparam int ADDR_W  = 3;
    localparam int CODE_W  = 4;
    localparam int WORD_W  = 1 + ADDR_W + CODE_W;
    localparam int NUM_CH  = 1 << ADDR_W;
    localparam int SYNC_ST = 2;

    typedef logic [CODE_W-1:0]        gain_code_t;
    typedef logic signed [CODE_W-1:0] step_t;

    localparam gain_code_t PWR_CODE = '0;
    localparam gain_code_t MID_CODE = gain_code_t'(1 << (CODE_W - 1));

    // Decoded control word: enable bit on top, channel, then gain code.
    typedef struct packed {
        logic                  en;
        logic [ADDR_W-1:0]     ch;
        gain_code_t            code;
    } ctrl_word_t;

    function automatic logic is_pwr(input gain_code_t c);
        return c == PWR_CODE;
    endfunction

    // Offset-binary to two's complement: code - midpoint, zero in powersave.
    function automatic step_t code_to_step(input gain_code_t c);
        if (is_pwr(c))
            return '0;
        return step_t'(c ^ MID_CODE);
    endfunction
endpackage

// File: rtl/sgb_sync.sv
module sgb_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= {STAGES{RST_VAL[b]}};
            else
                chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sgb_word_rx.sv
module sgb_word_rx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_lvl_i,
    input  logic              sdat_lvl_i,
    input  logic              latch_lvl_i,
    output logic              frame_ok_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    logic              sclk_prev, latch_prev;
    logic              sclk_rise, latch_fall;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    assign sclk_rise  = sclk_lvl_i & ~sclk_prev;
    assign latch_fall = ~latch_lvl_i & latch_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev  <= 1'b0;
            latch_prev <= 1'b1;
            shreg      <= '0;
            cnt        <= '0;
        end else begin
            sclk_prev  <= sclk_lvl_i;
            latch_prev <= latch_lvl_i;
            if (latch_fall) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdat_lvl_i};
                if (cnt != CNT_OVER)
                    cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_ok_o = latch_fall && (cnt == CNT_FULL);
    assign word_o     = shreg;
endmodule

// File: rtl/sgb_chan_bank.sv
module sgb_chan_bank
    import sgb_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int A_W   = ADDR_W,
    parameter int C_W   = CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [A_W-1:0]   wr_ch_i,
    input  logic [C_W-1:0]   wr_code_i,
    output logic [N_CH*C_W-1:0] code_o,
    output logic [N_CH-1:0]  pwr_o,
    output logic [N_CH*C_W-1:0] step_o,
    output logic             upd_o,
    output logic [A_W-1:0]   upd_ch_o
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        gain_code_t code_q;
        always_ff @(posedge clk) begin
            if (rst)
                code_q <= PWR_CODE;
            else if (wr_en_i && (wr_ch_i == A_W'(i)))
                code_q <= wr_code_i;
        end
        assign code_o[i*C_W +: C_W] = code_q;
        assign pwr_o[i]             = is_pwr(code_q);
        assign step_o[i*C_W +: C_W] = code_to_step(code_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_o    <= 1'b0;
            upd_ch_o <= '0;
        end else begin
            upd_o <= wr_en_i;
            if (wr_en_i)
                upd_ch_o <= wr_ch_i;
        end
    end
endmodule

// File: rtl/serial_gain_bank.sv
module serial_gain_bank
    import sgb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_clk_i,
    input  logic                     ser_dat_i,
    input  logic                     latch_n_i,
    output logic [NUM_CH*CODE_W-1:0] gain_code_o,
    output logic [NUM_CH-1:0]        pwr_save_o,
    output logic [NUM_CH*CODE_W-1:0] step_o,
    output logic                     upd_o,
    output logic [ADDR_W-1:0]        upd_ch_o
);
    // Sync vector order: {latch_n, data, clock}; strobe idles high.
    logic [2:0]        sync_q;
    logic              frame_ok;
    logic [WORD_W-1:0] raw_word;
    ctrl_word_t        word;
    logic              accept;

    sgb_sync #(.N(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({latch_n_i, ser_dat_i, ser_clk_i}),
        .q_o (sync_q)
    );

    sgb_word_rx #(.WORD_W(WORD_W)) rx_i (
        .clk         (clk),
        .rst         (rst),
        .sclk_lvl_i  (sync_q[0]),
        .sdat_lvl_i  (sync_q[1]),
        .latch_lvl_i (sync_q[2]),
        .frame_ok_o  (frame_ok),
        .word_o      (raw_word)
    );

    assign word   = ctrl_word_t'(raw_word);
    assign accept = frame_ok && word.en;

    sgb_chan_bank #(.N_CH(NUM_CH), .A_W(ADDR_W), .C_W(CODE_W)) bank_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (accept),
        .wr_ch_i   (word.ch),
        .wr_code_i (word.code),
        .code_o    (gain_code_o),
        .pwr_o     (pwr_save_o),
        .step_o    (step_o),
        .upd_o     (upd_o),
        .upd_ch_o  (upd_ch_o)
    );
endmodule

// File: rtl/sgb_checker.sv
module sgb_checker
    import sgb_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH*CODE_W-1:0] gain_code_o,
    input logic [NUM_CH-1:0]        pwr_save_o,
    input logic [NUM_CH*CODE_W-1:0] step_o,
    input logic                     upd_o,
    input logic [ADDR_W-1:0]        upd_ch_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (gain_code_o == '0 && pwr_save_o == '1 && step_o == '0 && !upd_o));

    assert_hold_without_update_R4: assert property (@(posedge clk) disable iff (rst)
        !upd_o |-> $stable(gain_code_o));

    assert_update_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        upd_o |=> !upd_o);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_other_channels_kept_R9: assert property (@(posedge clk) disable iff (rst)
            (upd_o && upd_ch_o != ADDR_W'(i)) |-> $stable(gain_code_o[i*CODE_W +: CODE_W]));

        assert_pwrsave_step_zero_R7: assert property (@(posedge clk) disable iff (rst)
            pwr_save_o[i] |-> (step_o[i*CODE_W +: CODE_W] == '0));

        assert_step_never_min_R7: assert property (@(posedge clk) disable iff (rst)
            step_o[i*CODE_W +: CODE_W] != MID_CODE);
    end
endmodule

bind serial_gain_bank sgb_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .gain_code_o (gain_code_o),
    .pwr_save_o  (pwr_save_o),
    .step_o      (step_o),
    .upd_o       (upd_o),
    .upd_ch_o    (upd_ch_o)
);

// File: tb/serial_gain_bank_tb_top.sv
module serial_gain_bank_tb_top;
    localparam int HALF = 4;
    localparam int NCH  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        latch_n = 1'b1;
    logic [31:0] gain_code;
    logic [7:0]  pwr_save;
    logic [31:0] step;
    logic        upd;
    logic [2:0]  upd_ch;

    int n_checks = 0;
    int n_fail   = 0;
    int upd_seen = 0;
    int upd_exp  = 0;
    int last_ch  = 0;
    int exp_code [NCH];

    always #10 clk = ~clk;

    serial_gain_bank dut_i (
        .clk (clk), .rst (rst),
        .ser_clk_i (ser_clk), .ser_dat_i (ser_dat), .latch_n_i (latch_n),
        .gain_code_o (gain_code), .pwr_save_o (pwr_save), .step_o (step),
        .upd_o (upd), .upd_ch_o (upd_ch)
    );

    always @(negedge clk) begin
        if (!rst && upd) begin
            upd_seen++;
            last_ch = int'(upd_ch);
        end
    end

    function automatic int exp_step(input int c);
        return (c == 0) ? 0 : c - 8;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++) begin
            int c = int'(gain_code[i*4 +: 4]);
            int s = int'($signed(step[i*4 +: 4]));
            chk(c == exp_code[i], req, $sformatf("code ch%0d", i), c, exp_code[i]);
            chk(int'(pwr_save[i]) == int'(exp_code[i] == 0), "R6", $sformatf("pwrsave ch%0d", i),
                int'(pwr_save[i]), int'(exp_code[i] == 0));
            chk(s == exp_step(exp_code[i]), "R7", $sformatf("step ch%0d", i), s, exp_step(exp_code[i]));
        end
        chk(upd_seen == upd_exp, "R8", "update pulse count", upd_seen, upd_exp);
    endtask

    task automatic send_bits(input logic [15:0] v, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk) ser_dat = v[i];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe();
        repeat (HALF) @(negedge clk);
        latch_n = 1'b0;
        repeat (HALF) @(negedge clk);
        latch_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Send a frame and update the model as the requirements dictate.
    task automatic frame(input logic [15:0] v, input int nbits);
        send_bits(v, nbits);
        strobe();
        if (nbits == 8 && v[7]) begin
            exp_code[int'(v[6:4])] = int'(v[3:0]);
            upd_exp++;
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < NCH; i++) exp_code[i] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(gain_code == '0, "R1", "codes after reset", int'(gain_code), 0);
        chk(pwr_save == 8'hFF, "R1", "powersave after reset", int'(pwr_save), 255);
        chk(upd == 1'b0, "R1", "update after reset", int'(upd), 0);
        check_all("R1");

        // R2, R7: first channel, midpoint code
        frame(16'h0088, 8);
        check_all("R2");
        chk(last_ch == 0, "R8", "update channel", last_ch, 0);
        // last channel, top code
        frame(16'h00FF, 8);
        check_all("R2");
        chk(last_ch == 7, "R8", "update channel", last_ch, 7);
        // R7: bottom code on channel index 4
        frame(16'h00C1, 8);
        check_all("R7");

        // R4: shifted but not strobed -> no change
        send_bits(16'h00A5, 8);
        repeat (8) @(negedge clk);
        check_all("R4");
        strobe();
        exp_code[2] = 5;
        upd_exp++;
        check_all("R4");
        chk(last_ch == 2, "R8", "update channel", last_ch, 2);

        // R3: enable bit zero
        frame(16'h0037, 8);
        check_all("R3");

        // R5: short and long frames, then a valid one
        frame(16'h007C, 7);
        check_all("R5");
        frame(16'h01D3, 9);
        check_all("R5");
        frame(16'h00D3, 8);
        check_all("R5");

        // R6: back to powersave
        frame(16'h00F0, 8);
        check_all("R6");

        // R9 and all others under random stimulus
        void'($urandom(32'h5EED));
        for (int it = 0; it < 48; it++) begin
            logic [15:0] v;
            int nb;
            v  = 16'($urandom);
            nb = ($urandom % 6 == 0) ? (($urandom % 2 == 0) ? 7 : 9) : 8;
            frame(v, nb);
            check_all("R9");
        end
        finish_up();
    end
endmodule